// File: doc/BRIEF.md
# Shared Chunk-Pool Packet Switch

This block is the core of a single-clock cut-through packet switch. Each input port takes bytes into a small private FIFO. An arbiter moves one byte per cycle from an input FIFO into a central memory. That memory is split into fixed-size chunks and shared by every output. Each output keeps a linked chain of chunks, with a head and a tail pointer, and one byte per cycle is read from a chain into a small per-output FIFO that drives the output port. Chunks are taken from a free pool as a packet is written. A chunk goes back to the pool once its last byte has been moved to an output FIFO.

Packets are source routed and may differ in length. Byte 0 is the route byte, and its low log2(NPORT) bits name the output port. Byte 1 is a payload length L from 0 to 253. L payload bytes follow, so a packet is at most 255 bytes. The switch forwards all L+2 bytes unchanged.

A packet owns its output from its first byte to its last, so packets on one output never interleave. When several inputs want a free output at once, the input served least recently on that output wins. Forwarding starts as soon as the route byte reaches the central memory, so a packet can leave before its tail has arrived. Backpressure is applied only by filling the input FIFO. NPORT must be a power of two.

Top module: `cq_switch`

## Requirements
- R1: After reset every in_ready is 1 and every out_valid is 0.
- R2: A packet leaves only on the output named by the low log2(NPORT) bits of its route byte; the upper route bits do not affect routing, and every byte leaves unchanged.
- R3: The byte after the route byte is the payload length L (0 to 253); exactly L+2 bytes are forwarded, including for L = 0 and L = 253.
- R4: Packets from one input to one output leave in arrival order, and bytes of different packets never interleave on an output.
- R5: Cut-through: the first byte of a packet can appear on its output before the last byte of that packet has been accepted at the input.
- R6: in_ready falls only when that input FIFO holds IDEPTH (31) bytes. With output 0 blocked and a stream of 2-byte packets to it, input 0 accepts exactly 293 bytes before stalling under default parameters: 7 in the output FIFO, 255 in the 128 chunks, and 31 in the input FIFO.
- R7: No accepted byte is lost. After a stall caused by an exhausted pool is released, every accepted byte is delivered in order.
- R8: When two inputs keep requesting the same output, packet ownership alternates between them, because the input served least recently on that output wins.
- R9: A blocked output does not stop traffic to other outputs. While out_valid is 1 and out_ready is 0, out_valid and out_data hold.
- R10: Every chunk returns to the pool once drained: a second run of the R6 stream accepts the same 293 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single switch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | NPORT*8 | Input byte per port, port p at bits p*8+7:p*8 |
| in_valid | input | NPORT | Input byte valid per port |
| in_ready | output | NPORT | Input FIFO can take a byte |
| out_data | output | NPORT*8 | Output byte per port |
| out_valid | output | NPORT | Output byte valid per port |
| out_ready | input | NPORT | Downstream takes the output byte |

## Verification
The risky overlap is the writer starting a new chunk for an output in the same cycle that the reader finishes the last stored byte of that output's chain. In that cycle the head pointer must be reloaded from the writer rather than from the stale link. Back-to-back short packets to one draining output provoke this case. The two-input contention run and the 2-byte packet stream both do so. It is judged by byte-exact delivery in order on that output, and by assertions that a non-empty queue always has a valid head and that the pool is full whenever all queues are idle.

// File: rtl/cq_switch.sv
module cq_switch #(
  parameter int NPORT      = 4,
  parameter int NCHUNK_LOG = 7,
  parameter int CHUNK_LOG  = 3,
  parameter int IDEPTH     = 31,
  parameter int ODEPTH     = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPORT*8-1:0] in_data,
  input  logic [NPORT-1:0]   in_valid,
  output logic [NPORT-1:0]   in_ready,
  output logic [NPORT*8-1:0] out_data,
  output logic [NPORT-1:0]   out_valid,
  input  logic [NPORT-1:0]   out_ready
);
  localparam int PW     = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int NCHUNK = 1 << NCHUNK_LOG;
  localparam int CB     = 1 << CHUNK_LOG;
  localparam int AW     = NCHUNK_LOG + CHUNK_LOG;
  localparam int IW     = $clog2(IDEPTH + 1);
  localparam int OW     = $clog2(ODEPTH + 1);
  localparam int QW     = AW + 1;

  logic [7:0]            ifd [NPORT][IDEPTH];
  logic [IW-1:0]         iwp [NPORT], irp [NPORT], icnt [NPORT];
  logic [NPORT-1:0]      ibusy, iphase;
  logic [PW-1:0]         iport [NPORT];
  logic [NCHUNK_LOG-1:0] ichunk [NPORT];
  logic [CHUNK_LOG-1:0]  ioff [NPORT];
  logic [7:0]            irem [NPORT];

  logic [8:0]            mem [NCHUNK*CB];
  logic [NCHUNK_LOG-1:0] nxt [NCHUNK];
  logic [NCHUNK-1:0]     free_map;
  logic [NCHUNK_LOG-1:0] qhead [NPORT], qtail [NPORT];
  logic [CHUNK_LOG-1:0]  roff [NPORT];
  logic [QW-1:0]         qcnt [NPORT];
  logic [NPORT-1:0]      hvalid;

  logic [7:0]            ofd [NPORT][ODEPTH];
  logic [OW-1:0]         owp [NPORT], orp [NPORT], ocnt [NPORT];
  logic [PW-1:0]         lrs [NPORT];
  logic [PW-1:0]         wrr, rrr;

  logic                  fany;
  logic [NCHUNK_LOG-1:0] fhead;
  logic [7:0]            ih [NPORT];
  logic [PW-1:0]         dest [NPORT], gw [NPORT];
  logic [NPORT-1:0]      needc, obusy, gv, elig, rcand;
  logic                  wgo, rgo;
  logic [PW-1:0]         wsel, rsel;

  always_comb begin
    fany  = |free_map;
    fhead = '0;
    for (int c = NCHUNK - 1; c >= 0; c--)
      if (free_map[c]) fhead = NCHUNK_LOG'(c);
  end

  always_comb begin
    obusy = '0;
    for (int i = 0; i < NPORT; i++) begin
      ih[i]    = ifd[i][irp[i]];
      dest[i]  = ibusy[i] ? iport[i] : ih[i][PW-1:0];
      needc[i] = !ibusy[i] || (ioff[i] == '0);
      in_ready[i] = (icnt[i] != IW'(IDEPTH));
      if (ibusy[i]) obusy[iport[i]] = 1'b1;
    end
    for (int o = 0; o < NPORT; o++) begin
      gv[o] = 1'b0;
      gw[o] = '0;
      for (int k = 0; k < NPORT; k++) begin
        int j;
        j = (int'(lrs[o]) + k) % NPORT;
        if (!gv[o] && icnt[j] != '0 && !ibusy[j] && ih[j][PW-1:0] == PW'(o)) begin
          gv[o] = 1'b1;
          gw[o] = PW'(j);
        end
      end
    end
    for (int i = 0; i < NPORT; i++)
      elig[i] = (icnt[i] != '0) && (!needc[i] || fany) &&
                (ibusy[i] || (!obusy[dest[i]] && gv[dest[i]] && gw[dest[i]] == PW'(i)));
    wgo = 1'b0;
    wsel = '0;
    for (int k = 0; k < NPORT; k++) begin
      int j;
      j = (int'(wrr) + k) % NPORT;
      if (!wgo && elig[j]) begin wgo = 1'b1; wsel = PW'(j); end
    end
    for (int o = 0; o < NPORT; o++)
      rcand[o] = (qcnt[o] != '0) && hvalid[o] && (ocnt[o] != OW'(ODEPTH));
    rgo = 1'b0;
    rsel = '0;
    for (int k = 0; k < NPORT; k++) begin
      int j;
      j = (int'(rrr) + k) % NPORT;
      if (!rgo && rcand[j]) begin rgo = 1'b1; rsel = PW'(j); end
    end
    for (int o = 0; o < NPORT; o++) begin
      out_valid[o]     = (ocnt[o] != '0);
      out_data[o*8+:8] = ofd[o][orp[o]];
    end
  end

  wire [PW-1:0]         wo    = dest[wsel];
  wire [7:0]            wb    = ih[wsel];
  wire                  wnew  = needc[wsel];
  wire [NCHUNK_LOG-1:0] wch   = wnew ? fhead : ichunk[wsel];
  wire [CHUNK_LOG-1:0]  woff  = wnew ? '0 : ioff[wsel];
  wire                  weop  = ibusy[wsel] && (iphase[wsel] ? (irem[wsel] == 8'd1) : (wb == 8'd0));
  wire [8:0]            rword = mem[{qhead[rsel], roff[rsel]}];
  wire                  rdone = rword[8] || (roff[rsel] == CHUNK_LOG'(CB - 1));
  wire                  rlast = (qcnt[rsel] == QW'(1));
  wire                  live  = hvalid[wo] && !(rgo && rsel == wo && rdone && rlast);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPORT; i++)
      if (in_valid[i] && in_ready[i]) ifd[i][iwp[i]] <= in_data[i*8+:8];
    if (wgo) begin
      mem[{wch, woff}] <= {weop, wb};
      if (wnew && live) nxt[qtail[wo]] <= fhead;
    end
    if (rgo) ofd[rsel][owp[rsel]] <= rword[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_map <= '1;
      ibusy    <= '0;
      iphase   <= '0;
      hvalid   <= '0;
      wrr      <= '0;
      rrr      <= '0;
      for (int i = 0; i < NPORT; i++) begin
        iwp[i] <= '0; irp[i] <= '0; icnt[i] <= '0;
        iport[i] <= '0; ichunk[i] <= '0; ioff[i] <= '0; irem[i] <= '0;
        qhead[i] <= '0; qtail[i] <= '0; roff[i] <= '0; qcnt[i] <= '0;
        owp[i] <= '0; orp[i] <= '0; ocnt[i] <= '0; lrs[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        logic ipush, ipop, opush, opop;
        ipush = in_valid[i] && in_ready[i];
        ipop  = wgo && wsel == PW'(i);
        opush = rgo && rsel == PW'(i);
        opop  = out_valid[i] && out_ready[i];
        if (ipush) iwp[i] <= (iwp[i] == IW'(IDEPTH - 1)) ? '0 : iwp[i] + 1'b1;
        if (ipop)  irp[i] <= (irp[i] == IW'(IDEPTH - 1)) ? '0 : irp[i] + 1'b1;
        icnt[i] <= icnt[i] + IW'(ipush) - IW'(ipop);
        if (opush) owp[i] <= (owp[i] == OW'(ODEPTH - 1)) ? '0 : owp[i] + 1'b1;
        if (opop)  orp[i] <= (orp[i] == OW'(ODEPTH - 1)) ? '0 : orp[i] + 1'b1;
        ocnt[i] <= ocnt[i] + OW'(opush) - OW'(opop);
        qcnt[i] <= qcnt[i] + QW'(wgo && wo == PW'(i)) - QW'(opush);
      end
      if (rgo) begin
        rrr        <= rsel + 1'b1;
        roff[rsel] <= roff[rsel] + 1'b1;
        if (rdone) begin
          free_map[qhead[rsel]] <= 1'b1;
          roff[rsel] <= '0;
          if (rlast) hvalid[rsel] <= 1'b0;
          else       qhead[rsel]  <= nxt[qhead[rsel]];
        end
      end
      if (wgo) begin
        wrr          <= wsel + 1'b1;
        ioff[wsel]   <= woff + 1'b1;
        ichunk[wsel] <= wch;
        if (wnew) begin
          free_map[fhead] <= 1'b0;
          qtail[wo]       <= fhead;
          if (!live) begin
            qhead[wo]  <= fhead;
            hvalid[wo] <= 1'b1;
          end
        end
        if (!ibusy[wsel]) begin
          ibusy[wsel]  <= 1'b1;
          iphase[wsel] <= 1'b0;
          iport[wsel]  <= wb[PW-1:0];
          lrs[wo]      <= wsel + 1'b1;
        end else if (!iphase[wsel]) begin
          iphase[wsel] <= 1'b1;
          irem[wsel]   <= wb;
          if (wb == 8'd0) ibusy[wsel] <= 1'b0;
        end else begin
          irem[wsel] <= irem[wsel] - 8'd1;
          if (irem[wsel] == 8'd1) ibusy[wsel] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cq_switch_chk.sv
module cq_switch_chk #(
  parameter int NPORT  = 4,
  parameter int NCHUNK = 128,
  parameter int PW     = 2,
  parameter int QW     = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NPORT*8-1:0] out_data,
  input logic [NPORT-1:0]   out_valid,
  input logic [NPORT-1:0]   out_ready,
  input logic [NCHUNK-1:0]  free_map,
  input logic [NPORT-1:0]   hvalid,
  input logic [NPORT-1:0]   ibusy,
  input logic [PW-1:0]      iport [NPORT],
  input logic [QW-1:0]      qcnt [NPORT]
);
  logic all_idle;
  always_comb begin
    all_idle = (ibusy == '0);
    for (int o = 0; o < NPORT; o++)
      if (qcnt[o] != '0) all_idle = 1'b0;
  end

  // R10
  pool_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_idle |-> (&free_map));

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    logic [NPORT-1:0] owners;
    always_comb
      for (int i = 0; i < NPORT; i++)
        owners[i] = ibusy[i] && (iport[i] == PW'(o));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_data[o*8+:8]));
    // R4
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(owners) <= 1);
    // R4
    head_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qcnt[o] != '0) |-> hvalid[o]);
  end
endmodule

bind cq_switch cq_switch_chk #(.NPORT(NPORT), .NCHUNK(NCHUNK), .PW(PW), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_data(out_data), .out_valid(out_valid),
  .out_ready(out_ready), .free_map(free_map), .hvalid(hvalid), .ibusy(ibusy),
  .iport(iport), .qcnt(qcnt)
);

// File: tb/sim_cq_switch.sv
`timescale 1ns/1ps
module sim_cq_switch;
  typedef logic [7:0] bq_t [$];

  logic        clk, rst_n;
  logic [31:0] in_data, out_data;
  logic [3:0]  in_valid, in_ready, out_valid, out_ready;

  cq_switch u0 (.clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
                .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
                .out_ready(out_ready));

  // {src, route, len, expected port}
  localparam logic [31:0] VEC [8] = '{
    32'h00000500, 32'h01050001, 32'h02FE0C02, 32'h03030703,
    32'h00420902, 32'h02011401, 32'h018BFD03, 32'h03100100 };

  logic [7:0] src_q [4][$];
  logic [7:0] rx_q  [4][$];
  logic [3:0] fired;
  int cyc, n_chk, n_bad;
  int acc_cnt [4], last_acc [4], first_rx [4];

  initial begin clk = 0; forever #2.5 clk = ~clk; end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bq_t mkpkt(input logic [7:0] route, input logic [7:0] len, input logic [7:0] tag);
    bq_t q;
    q.push_back(route);
    q.push_back(len);
    for (int k = 0; k < int'(len); k++) q.push_back(tag + 8'(k * 7));
    return q;
  endfunction

  function automatic int diff(input bq_t a, input bq_t b);
    int d = (a.size() > b.size()) ? a.size() - b.size() : b.size() - a.size();
    for (int k = 0; k < a.size() && k < b.size(); k++) if (a[k] !== b[k]) d++;
    return d;
  endfunction

  task automatic send(input int s, input bq_t q);
    foreach (q[k]) src_q[s].push_back(q[k]);
  endtask

  task automatic wait_rx(input int p, input int n);
    int t = 0;
    while (rx_q[p].size() < n && t < 5000) begin @(negedge clk); t++; end
    repeat (10) @(negedge clk);
  endtask

  task automatic clear_rx();
    for (int p = 0; p < 4; p++) begin rx_q[p].delete(); first_rx[p] = -1; end
  endtask

  initial begin
    in_valid = '0; in_data = '0;
    forever begin
      @(posedge clk); #1;
      for (int i = 0; i < 4; i++) begin
        if (fired[i]) begin
          void'(src_q[i].pop_front());
          acc_cnt[i]++;
          last_acc[i] = cyc;
        end
        fired[i] = 1'b0;
        if (src_q[i].size() > 0) begin
          in_valid[i] = 1'b1;
          in_data[i*8+:8] = src_q[i][0];
        end else in_valid[i] = 1'b0;
      end
    end
  end

  initial begin
    fired = '0;
    forever begin
      @(negedge clk);
      cyc++;
      for (int i = 0; i < 4; i++) fired[i] = in_valid[i] && in_ready[i];
      for (int p = 0; p < 4; p++)
        if (out_valid[p] === 1'b1 && out_ready[p]) begin
          rx_q[p].push_back(out_data[p*8+:8]);
          if (first_rx[p] < 0) first_rx[p] = cyc;
        end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic fill_run(input int run, output int accepted);
    bq_t exp;
    int low = 0, t = 0;
    @(posedge clk); #1;
    out_ready[0] = 1'b0;
    acc_cnt[0] = 0;
    clear_rx();
    for (int k = 0; k < 200; k++) begin
      bq_t q = mkpkt({k[5:0], 2'b00}, 8'd0, 8'd0);
      send(0, q);
      foreach (q[j]) exp.push_back(q[j]);
    end
    while (low < 40 && t < 4000) begin
      @(negedge clk); t++;
      low = in_ready[0] ? 0 : low + 1;
    end
    accepted = acc_cnt[0];
    @(posedge clk); #1;
    out_ready[0] = 1'b1;
    wait_rx(0, 400);
    // R7: all bytes delivered in order after release
    check(diff(rx_q[0], exp) == 0, run == 0 ? "R7 drain" : "R7 second drain", diff(rx_q[0], exp), 0);
  endtask

  initial begin
    int acc1, acc2;
    bq_t e, a0, a1, b0, b1;
    n_chk = 0; n_bad = 0; cyc = 0;
    for (int i = 0; i < 4; i++) begin acc_cnt[i] = 0; last_acc[i] = 0; end
    out_ready = '1;
    rst_n = 1'b0;
    clear_rx();
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 4'hF, "R1 in_ready", in_ready, 15);
    check(out_valid == 4'h0, "R1 out_valid", out_valid, 0);

    // R2 R3: table walk, one packet at a time
    for (int v = 0; v < 8; v++) begin
      int s, p, l;
      s = int'(VEC[v][31:24]); p = int'(VEC[v][7:0]); l = int'(VEC[v][15:8]);
      clear_rx();
      e = mkpkt(VEC[v][23:16], VEC[v][15:8], 8'(v * 29));
      send(s, e);
      wait_rx(p, l + 2);
      check(diff(rx_q[p], e) == 0, "R2 content", diff(rx_q[p], e), 0);
      check(rx_q[p].size() == l + 2, "R3 length", rx_q[p].size(), l + 2);
      for (int q = 0; q < 4; q++)
        if (q != p) check(rx_q[q].size() == 0, "R2 stray", rx_q[q].size(), 0);
    end

    // R4: three packets from one input, output throttled
    clear_rx();
    a0 = mkpkt(8'h07, 8'd4, 8'h31);
    a1 = mkpkt(8'h0B, 8'd11, 8'h52);
    b0 = mkpkt(8'h03, 8'd0, 8'h00);
    send(2, a0); send(2, a1); send(2, b0);
    e = a0; foreach (a1[k]) e.push_back(a1[k]); foreach (b0[k]) e.push_back(b0[k]);
    for (int k = 0; k < 40; k++) begin @(posedge clk); #1; out_ready[3] = k[0]; end
    @(posedge clk); #1; out_ready[3] = 1'b1;
    wait_rx(3, e.size());
    check(diff(rx_q[3], e) == 0, "R4 order", diff(rx_q[3], e), 0);

    // R5: cut-through on a long packet
    clear_rx();
    send(3, mkpkt(8'h01, 8'd60, 8'h77));
    wait_rx(1, 62);
    check(first_rx[1] >= 0 && first_rx[1] < last_acc[3], "R5 cut-through", first_rx[1], last_acc[3]);

    // R8: two inputs contend for output 2
    clear_rx();
    a0 = mkpkt(8'h02, 8'd3, 8'hA0); a1 = mkpkt(8'h02, 8'd3, 8'hA1);
    b0 = mkpkt(8'h02, 8'd3, 8'hB0); b1 = mkpkt(8'h02, 8'd3, 8'hB1);
    send(0, a0); send(0, a1); send(1, b0); send(1, b1);
    wait_rx(2, 20);
    e.delete();
    if (rx_q[2].size() > 2 && rx_q[2][2] == 8'hB0) begin
      foreach (b0[k]) e.push_back(b0[k]); foreach (a0[k]) e.push_back(a0[k]);
      foreach (b1[k]) e.push_back(b1[k]); foreach (a1[k]) e.push_back(a1[k]);
    end else begin
      foreach (a0[k]) e.push_back(a0[k]); foreach (b0[k]) e.push_back(b0[k]);
      foreach (a1[k]) e.push_back(a1[k]); foreach (b1[k]) e.push_back(b1[k]);
    end
    check(diff(rx_q[2], e) == 0, "R8 alternation", diff(rx_q[2], e), 0);

    // R9: blocked output 0, output 1 keeps flowing
    clear_rx();
    @(posedge clk); #1; out_ready[0] = 1'b0;
    a0 = mkpkt(8'h00, 8'd20, 8'h11);
    b0 = mkpkt(8'h01, 8'd5, 8'h22);
    send(0, a0); send(1, b0);
    wait_rx(1, 7);
    check(diff(rx_q[1], b0) == 0, "R9 other port", diff(rx_q[1], b0), 0);
    begin
      logic [7:0] held;
      held = out_data[7:0];
      repeat (5) @(negedge clk);
      check(out_valid[0] == 1'b1, "R9 valid held", out_valid[0], 1);
      check(out_data[7:0] == held, "R9 data held", out_data[7:0], held);
    end
    @(posedge clk); #1; out_ready[0] = 1'b1;
    wait_rx(0, 22);
    check(diff(rx_q[0], a0) == 0, "R9 release", diff(rx_q[0], a0), 0);

    // R6 R10: pool exhaustion, twice
    fill_run(0, acc1);
    check(acc1 == 293, "R6 accepted", acc1, 293);
    fill_run(1, acc2);
    check(acc2 == 293, "R10 refill", acc2, 293);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule